// File: doc/BRIEF.md
# Serial EEPROM Request Sequencer

This block turns a single read or write request for a serial EEPROM into the series of framed byte transactions that the memory expects. A request names a 16-bit start address, a byte count and a direction. Write data is fetched from a caller-owned buffer by index, and read data is written back into that buffer by index. The bytes go through a byte-wide SPI master that is outside this block. The sequencer frames each transaction with an active-low chip select, issues one byte at a time and waits for the master to acknowledge each byte.

Any request longer than `CHUNK_MAX` bytes is cut into pieces of at most that size, and the memory address and buffer index advance by the length of each piece. Every written piece is preceded by its own write-enable frame. After the piece, the device status is polled until its busy bit clears. The number of polls is bounded, and the spacing between polls is set in clock cycles. When the poll limit is used up, a sticky timeout flag is raised and the sequencer moves on. A one-cycle done pulse marks the end of the request.

Top module: `eeprom_seq`

## Requirements
- R1: A request accepted with `req_len` of 0 produces `done` on the next cycle, with no frame opened and no byte issued.
- R2: A request is split into pieces of `min(remaining, CHUNK_MAX)` bytes. Each piece starts at the previous piece's address plus its length, modulo 2^16, and at the previous buffer index plus that same length.
- R3: In every read and write data frame, the two address bytes come straight after the opcode, high byte (address bits 15:8) first.
- R4: Each write piece is sent as a one-byte frame holding 0x06, then a separate frame holding 0x02, the address and the piece's bytes read from `buf_rd_data` at buffer index base+k.
- R5: After each write piece, status is polled with a two-byte frame {0x05, 0x00}. Only bit 0 of the second received byte is examined: 0 ends the piece, and 1 leads to another poll that opens no earlier than `POLL_CYCLES` cycles after the previous poll opened.
- R6: When `POLL_TRIES` polls of one piece all answer busy, `timeout` goes to 1 and the sequencer carries on with the next piece. `timeout` stays 1 until the next accepted request clears it.
- R7: Each read piece is sent as {0x03, addr hi, addr lo, n filler bytes 0x00}. The byte received at frame position 3+k is written to buffer index base+k.
- R8: `done` is high for exactly one cycle after the last piece completes, and `busy` is low in that cycle.
- R9: `req_start` is ignored while `busy` is high. The running request's frames are unchanged, and no frame for the ignored request appears afterwards.
- R10: After reset, `spi_cs_n` is 1 and `spi_go`, `busy`, `done`, `timeout` and `buf_wr_en` are 0.
- R11: `spi_go` is asserted only while `spi_cs_n` is low, and only one byte is outstanding at a time. A frame opens with its first byte in the same cycle that `spi_cs_n` falls, and `spi_cs_n` is high for at least one cycle between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | 16 | EEPROM start address |
| req_len | input | LEN_W | Number of bytes to move |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout | output | 1 | Sticky: a status poll limit was reached |
| buf_rd_idx | output | LEN_W | Buffer index of the write byte being sent |
| buf_rd_data | input | 8 | Buffer byte at `buf_rd_idx` (combinational) |
| buf_wr_en | output | 1 | Store one received read byte |
| buf_wr_idx | output | LEN_W | Buffer index for the received byte |
| buf_wr_data | output | 8 | Received read byte |
| spi_cs_n | output | 1 | Active-low chip select framing a transaction |
| spi_go | output | 1 | Issue `spi_txd` to the SPI master |
| spi_txd | output | 8 | Byte to shift out |
| spi_ack | input | 1 | Master finished the byte, `spi_rxd` valid |
| spi_rxd | input | 8 | Byte shifted in |

## Verification
The bench builds the block with `LEN_W` = 8, `CHUNK_MAX` = 16, `POLL_CYCLES` = 20 and `POLL_TRIES` = 4. These values shrink a 1 ms poll interval and a 1000-try limit to a few dozen cycles, so the bench can drive every poll outcome: ready at once, ready after several busy answers, and limit reached on every piece of a multi-piece write. With the short buffer index and the 16-byte piece size, the bench also covers an exact single piece, a three-piece read ending in a one-byte piece, and an address that wraps past 0xFFFF part-way through a request.

// File: rtl/eeprom_seq_pkg.sv
// Shared constants and state encodings for the EEPROM request sequencer.
package eeprom_seq_pkg;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_WRITE = 8'h02;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] FILLER   = 8'h00;

    typedef enum logic [1:0] {PH_WREN, PH_WRITE, PH_RDSR, PH_READ} phase_t;
    typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT, S_GAP} seq_state_t;
    typedef enum logic [1:0] {X_IDLE, X_SEND, X_WAIT} xact_state_t;
endpackage

// File: rtl/eeprom_chunker.sv
// Piece planner: holds the running address, buffer base index and remaining
// count of a request, and gives the size of the current piece.
// Assumes LEN_W is wide enough to hold CHUNK_MAX.
module eeprom_chunker #(
    parameter int LEN_W     = 16,
    parameter int CHUNK_MAX = 16,
    localparam int CW       = $clog2(CHUNK_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  logic [15:0]      ld_addr,
    input  logic [LEN_W-1:0] ld_len,
    output logic [15:0]      cur_addr,
    output logic [LEN_W-1:0] base_idx,
    output logic [CW-1:0]    piece_len,
    output logic             last_piece
);
    logic [LEN_W-1:0] remain;

    // Piece size is the remaining count clipped to the maximum.
    always_comb begin
        last_piece = (remain <= LEN_W'(CHUNK_MAX));
        piece_len  = last_piece ? CW'(remain) : CW'(CHUNK_MAX);
    end

    // Load on request, advance all three counters by one piece on demand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            base_idx <= '0;
            remain   <= '0;
        end else if (load) begin
            cur_addr <= ld_addr;
            base_idx <= '0;
            remain   <= ld_len;
        end else if (adv) begin
            cur_addr <= cur_addr + 16'(piece_len);
            base_idx <= base_idx + LEN_W'(piece_len);
            remain   <= remain - LEN_W'(piece_len);
        end
    end
endmodule

// File: rtl/eeprom_xact.sv
// Transaction engine: opens a chip-select frame, issues nbytes bytes one at a
// time (waiting for each acknowledge), and closes the frame after the last.
// Byte 0 is the opcode; bytes 1..2 the address for read/write opcodes;
// later bytes are buffer data for writes and filler otherwise.
// Assumes opcode, address and base index are stable while the frame runs.
module eeprom_xact import eeprom_seq_pkg::*; #(
    parameter int LEN_W = 16,
    parameter int BW    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic [BW-1:0]    nbytes,
    input  logic [15:0]      addr,
    input  logic [LEN_W-1:0] base_idx,
    input  logic [7:0]       wdata,
    output logic [LEN_W-1:0] rd_idx,
    output logic             rx_valid,
    output logic [BW-1:0]    rx_pos,
    output logic [7:0]       rx_byte,
    output logic             frame_done,
    output logic             spi_cs_n,
    output logic             spi_go,
    output logic [7:0]       spi_txd,
    input  logic             spi_ack,
    input  logic [7:0]       spi_rxd
);
    xact_state_t      st;
    logic [BW-1:0]    pos;
    logic [BW-1:0]    n_q;
    logic [7:0]       op_q;
    logic             has_addr;

    // Frame control signals and received-byte reporting.
    always_comb begin
        spi_cs_n   = (st == X_IDLE);
        spi_go     = (st == X_SEND);
        rx_valid   = (st == X_WAIT) && spi_ack;
        rx_pos     = pos;
        rx_byte    = spi_rxd;
        frame_done = rx_valid && (pos == n_q - BW'(1));
        rd_idx     = base_idx + LEN_W'(pos) - LEN_W'(3);
    end

    // Byte selection by position within the frame.
    always_comb begin
        has_addr = (op_q == OP_WRITE) || (op_q == OP_READ);
        if (pos == '0)
            spi_txd = op_q;
        else if (has_addr && pos == BW'(1))
            spi_txd = addr[15:8];
        else if (has_addr && pos == BW'(2))
            spi_txd = addr[7:0];
        else if (op_q == OP_WRITE)
            spi_txd = wdata;
        else
            spi_txd = FILLER;
    end

    // Send / wait-for-acknowledge loop over the bytes of one frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= X_IDLE;
            pos  <= '0;
            n_q  <= '0;
            op_q <= '0;
        end else begin
            case (st)
                X_IDLE: if (start) begin
                    op_q <= opcode;
                    n_q  <= nbytes;
                    pos  <= '0;
                    st   <= X_SEND;
                end
                X_SEND: st <= X_WAIT;
                X_WAIT: if (spi_ack) begin
                    if (pos == n_q - BW'(1)) begin
                        st <= X_IDLE;
                    end else begin
                        pos <= pos + BW'(1);
                        st  <= X_SEND;
                    end
                end
                default: st <= X_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/eeprom_poll_timer.sv
// Poll pacing: counts busy answers for the current piece and measures the
// idle interval between status polls. Assumes POLL_CYCLES and POLL_TRIES >= 1.
module eeprom_poll_timer #(
    parameter int POLL_CYCLES = 100000,
    parameter int POLL_TRIES  = 1000,
    localparam int GW         = $clog2(POLL_CYCLES + 1),
    localparam int TW         = $clog2(POLL_TRIES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_tries,
    input  logic note_busy,
    input  logic gap_en,
    output logic last_try,
    output logic gap_done
);
    logic [TW-1:0] tries;
    logic [GW-1:0] gap_cnt;

    // Limit reached when the busy answer now arriving is the final allowed one.
    always_comb begin
        last_try = (tries == TW'(POLL_TRIES - 1));
        gap_done = gap_en && (gap_cnt == GW'(POLL_CYCLES - 1));
    end

    // Busy-answer counter, cleared at the start of each piece's polling.
    always_ff @(posedge clk) begin
        if (!rst_n || clr_tries)
            tries <= '0;
        else if (note_busy)
            tries <= tries + TW'(1);
    end

    // Interval counter, running only while the sequencer waits between polls.
    always_ff @(posedge clk) begin
        if (!rst_n || !gap_en)
            gap_cnt <= '0;
        else
            gap_cnt <= gap_cnt + GW'(1);
    end
endmodule

// File: rtl/eeprom_seq.sv
// EEPROM request sequencer top: accepts a request when idle, walks it piece
// by piece through write-enable / write / status-poll or read frames, and
// reports done and timeout. Assumes a byte-wide SPI master that answers each
// spi_go with one spi_ack pulse, and a buffer read path with zero latency.
module eeprom_seq import eeprom_seq_pkg::*; #(
    parameter int LEN_W       = 16,
    parameter int CHUNK_MAX   = 16,
    parameter int POLL_CYCLES = 100000,
    parameter int POLL_TRIES  = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_start,
    input  logic             req_write,
    input  logic [15:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    output logic             busy,
    output logic             done,
    output logic             timeout,
    output logic [LEN_W-1:0] buf_rd_idx,
    input  logic [7:0]       buf_rd_data,
    output logic             buf_wr_en,
    output logic [LEN_W-1:0] buf_wr_idx,
    output logic [7:0]       buf_wr_data,
    output logic             spi_cs_n,
    output logic             spi_go,
    output logic [7:0]       spi_txd,
    input  logic             spi_ack,
    input  logic [7:0]       spi_rxd
);
    localparam int CW  = $clog2(CHUNK_MAX + 1);
    localparam int BW  = $clog2(CHUNK_MAX + 4);
    localparam int HDR = 3;

    seq_state_t       state;
    phase_t           phase;
    logic             wr_mode;
    logic             accept;
    logic [15:0]      cur_addr;
    logic [LEN_W-1:0] base_idx;
    logic [CW-1:0]    piece_len;
    logic             last_piece;
    logic             x_start;
    logic [7:0]       x_op;
    logic [BW-1:0]    x_n;
    logic             x_done;
    logic             rx_valid;
    logic [BW-1:0]    rx_pos;
    logic [7:0]       rx_byte;
    logic             last_try;
    logic             gap_done;
    logic             note_busy;
    logic             clr_tries;
    logic             piece_end;

    // Decode of the current phase into frame opcode and length.
    always_comb begin
        accept  = (state == S_IDLE) && req_start;
        busy    = (state != S_IDLE);
        x_start = (state == S_LAUNCH);
        case (phase)
            PH_WREN:  begin x_op = OP_WREN;  x_n = BW'(1); end
            PH_WRITE: begin x_op = OP_WRITE; x_n = BW'(HDR) + BW'(piece_len); end
            PH_RDSR:  begin x_op = OP_RDSR;  x_n = BW'(2); end
            default:  begin x_op = OP_READ;  x_n = BW'(HDR) + BW'(piece_len); end
        endcase
    end

    // Frame-end events that steer the sequence.
    always_comb begin
        clr_tries = (state == S_WAIT) && x_done && (phase == PH_WRITE);
        note_busy = (state == S_WAIT) && x_done && (phase == PH_RDSR) && rx_byte[0];
        piece_end = (state == S_WAIT) && x_done &&
                    ((phase == PH_READ) ||
                     ((phase == PH_RDSR) && (!rx_byte[0] || last_try)));
    end

    eeprom_chunker #(.LEN_W(LEN_W), .CHUNK_MAX(CHUNK_MAX)) u_chunk (
        .clk(clk), .rst_n(rst_n), .load(accept && req_len != '0), .adv(piece_end),
        .ld_addr(req_addr), .ld_len(req_len), .cur_addr(cur_addr),
        .base_idx(base_idx), .piece_len(piece_len), .last_piece(last_piece)
    );

    eeprom_xact #(.LEN_W(LEN_W), .BW(BW)) u_xact (
        .clk(clk), .rst_n(rst_n), .start(x_start), .opcode(x_op), .nbytes(x_n),
        .addr(cur_addr), .base_idx(base_idx), .wdata(buf_rd_data),
        .rd_idx(buf_rd_idx), .rx_valid(rx_valid), .rx_pos(rx_pos),
        .rx_byte(rx_byte), .frame_done(x_done), .spi_cs_n(spi_cs_n),
        .spi_go(spi_go), .spi_txd(spi_txd), .spi_ack(spi_ack), .spi_rxd(spi_rxd)
    );

    eeprom_poll_timer #(.POLL_CYCLES(POLL_CYCLES), .POLL_TRIES(POLL_TRIES)) u_poll (
        .clk(clk), .rst_n(rst_n), .clr_tries(clr_tries), .note_busy(note_busy),
        .gap_en(state == S_GAP), .last_try(last_try), .gap_done(gap_done)
    );

    // Main sequence: phase stepping, piece advance, done and timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            phase   <= PH_READ;
            wr_mode <= 1'b0;
            done    <= 1'b0;
            timeout <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                S_IDLE: if (accept) begin
                    timeout <= 1'b0;
                    wr_mode <= req_write;
                    phase   <= req_write ? PH_WREN : PH_READ;
                    if (req_len == '0)
                        done  <= 1'b1;
                    else
                        state <= S_LAUNCH;
                end
                S_LAUNCH: state <= S_WAIT;
                S_WAIT: if (x_done) begin
                    if (note_busy && last_try)
                        timeout <= 1'b1;
                    if (piece_end) begin
                        if (last_piece) begin
                            state <= S_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= S_LAUNCH;
                            phase <= wr_mode ? PH_WREN : PH_READ;
                        end
                    end else if (phase == PH_WREN) begin
                        phase <= PH_WRITE;
                        state <= S_LAUNCH;
                    end else if (phase == PH_WRITE) begin
                        phase <= PH_RDSR;
                        state <= S_LAUNCH;
                    end else begin
                        state <= S_GAP;
                    end
                end
                S_GAP: if (gap_done) state <= S_LAUNCH;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Registered store of received read bytes past the header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_wr_en   <= 1'b0;
            buf_wr_idx  <= '0;
            buf_wr_data <= '0;
        end else begin
            buf_wr_en   <= rx_valid && (phase == PH_READ) && (rx_pos >= BW'(HDR));
            buf_wr_idx  <= base_idx + LEN_W'(rx_pos) - LEN_W'(HDR);
            buf_wr_data <= rx_byte;
        end
    end
endmodule

// File: rtl/eeprom_seq_chk.sv
// Property checker for the EEPROM request sequencer, attached by bind.
module eeprom_seq_chk #(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_start,
    input logic [LEN_W-1:0] req_len,
    input logic             busy,
    input logic             done,
    input logic             timeout,
    input logic             spi_cs_n,
    input logic             spi_go,
    input logic             buf_wr_en
);
    // R11: a byte is issued only inside a frame
    p_go_in_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
        spi_go |-> !spi_cs_n);

    // R11: a frame opens together with its first byte
    p_frame_opens_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> spi_go);

    // R11: one byte in flight, so no back-to-back issue
    p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
        spi_go |=> !spi_go);

    // R8: done lasts a single cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done comes with busy low
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10: no bus activity while idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (spi_cs_n && !spi_go));

    // R1: empty request finishes next cycle without opening a frame
    p_zero_len_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && !busy && req_len == '0) |=> (done && spi_cs_n && !busy));

    // R6: timeout holds until a request is accepted
    p_timeout_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout && !(req_start && !busy)) |=> timeout);

    // R7: buffer stores happen only while a frame is closing or open
    p_wr_in_request_r7: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr_en |-> $past(busy));
endmodule

bind eeprom_seq eeprom_seq_chk #(.LEN_W(LEN_W)) u_eeprom_seq_chk (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_len(req_len),
    .busy(busy), .done(done), .timeout(timeout), .spi_cs_n(spi_cs_n),
    .spi_go(spi_go), .buf_wr_en(buf_wr_en)
);

// File: tb/tb_eeprom_seq.sv
`timescale 1ns/1ps
module tb_eeprom_seq;
    localparam int LEN_W   = 8;
    localparam int CHUNK   = 16;
    localparam int PC      = 20;
    localparam int TRIES   = 4;
    localparam int ACK_LAT = 2;

    // {write(8), addr(16), len(8), busy answers per piece(8)}
    localparam logic [39:0] VEC [0:6] = '{
        {8'd1, 16'h1234, 8'd5,  8'd0},
        {8'd1, 16'h00F8, 8'd16, 8'd2},
        {8'd1, 16'hFFF8, 8'd20, 8'd1},
        {8'd0, 16'h0040, 8'd7,  8'd0},
        {8'd0, 16'hABF0, 8'd33, 8'd0},
        {8'd1, 16'h2000, 8'd17, 8'd5},
        {8'd0, 16'h0000, 8'd16, 8'd0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_start = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic busy, done, timeout, buf_wr_en, spi_cs_n, spi_go;
    logic [LEN_W-1:0] buf_rd_idx, buf_wr_idx;
    logic [7:0] buf_rd_data, buf_wr_data, spi_txd;
    logic spi_ack = 1'b0;
    logic [7:0] spi_rxd = '0;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int ntot = 0, log_base = 0, cur_f = 0, cur_bp = 0, busy_left = 0, ack_cnt = 0;
    logic cs_prev = 1'b1;
    logic [7:0] pend_rx;
    logic [7:0] lb [0:63][0:23];
    int ll [0:63];
    int lt [0:63];
    logic [7:0] rdbuf [0:255];
    logic [7:0] exp_b [0:23];
    int exp_n;

    always #5 clk = ~clk;

    function automatic logic [7:0] src_byte(input logic [7:0] i);
        return i * 8'd7 + 8'h11;
    endfunction
    function automatic logic [7:0] pat(input logic [15:0] a);
        return a[7:0] ^ (a[15:8] + 8'h5B);
    endfunction

    assign buf_rd_data = src_byte(buf_rd_idx);

    eeprom_seq #(.LEN_W(LEN_W), .CHUNK_MAX(CHUNK), .POLL_CYCLES(PC), .POLL_TRIES(TRIES)) dut (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
        .req_addr(req_addr), .req_len(req_len), .busy(busy), .done(done),
        .timeout(timeout), .buf_rd_idx(buf_rd_idx), .buf_rd_data(buf_rd_data),
        .buf_wr_en(buf_wr_en), .buf_wr_idx(buf_wr_idx), .buf_wr_data(buf_wr_data),
        .spi_cs_n(spi_cs_n), .spi_go(spi_go), .spi_txd(spi_txd),
        .spi_ack(spi_ack), .spi_rxd(spi_rxd)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Device model: logs frames, answers status and read bytes, acknowledges.
    always @(negedge clk) begin
        int p, f;
        logic [7:0] op;
        logic [15:0] a;
        spi_ack <= 1'b0;
        if (rst_n) begin
            if (!spi_cs_n && cs_prev) begin
                f = (ntot - log_base) % 64;
                ntot = ntot + 1;
                ll[f] = 0;
                lt[f] = cyc;
                cur_f = f;
            end
            cs_prev = spi_cs_n;
            if (spi_go) begin
                p = ll[cur_f];
                if (p < 24) lb[cur_f][p] = spi_txd;
                ll[cur_f] = p + 1;
                op = (p == 0) ? spi_txd : lb[cur_f][0];
                pend_rx = 8'hC3;
                if (op == 8'h02 && p == 0) busy_left = cur_bp;
                if (op == 8'h05 && p == 1) begin
                    pend_rx = (busy_left > 0) ? 8'h01 : 8'hFE;
                    if (busy_left > 0) busy_left = busy_left - 1;
                end
                if (op == 8'h03 && p >= 3) begin
                    a = {lb[cur_f][1], lb[cur_f][2]} + 16'(p - 3);
                    pend_rx = pat(a);
                end
                ack_cnt = ACK_LAT;
            end else if (ack_cnt > 0) begin
                ack_cnt = ack_cnt - 1;
                if (ack_cnt == 0) begin
                    spi_ack <= 1'b1;
                    spi_rxd <= pend_rx;
                end
            end
        end
    end

    always @(negedge clk) if (buf_wr_en) rdbuf[buf_wr_idx] = buf_wr_data;

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic cmp_frame(input int f, input string what);
        bit ok = (ll[f] == exp_n);
        int act = ll[f], exp = exp_n;
        for (int k = 0; k < exp_n && ok; k++)
            if (lb[f][k] != exp_b[k]) begin ok = 0; act = lb[f][k]; exp = exp_b[k]; end
        check(ok, what, act, exp);
    endtask

    task automatic start_req(input bit w, input logic [15:0] a, input int len, input int bp);
        @(negedge clk);
        log_base = ntot;
        cur_bp = bp;
        req_write = w; req_addr = a; req_len = LEN_W'(len); req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
    endtask

    task automatic wait_done(input string what);
        bit got = 0;
        for (int i = 0; i < 5000; i++) begin
            if (done) begin got = 1; break; end
            @(negedge clk);
        end
        check(got && !busy, {what, " R8 done with busy low"}, {busy, got}, 2'b01);
        @(negedge clk);
        check(!done, "R8 done lasts one cycle", done, 0);
        @(negedge clk);
    endtask

    task automatic verify(input bit w, input logic [15:0] a0, input int len, input int bp);
        int e = 0;
        for (int off = 0; off < len; off += CHUNK) begin
            int n = (len - off > CHUNK) ? CHUNK : len - off;
            logic [15:0] a = a0 + 16'(off);
            if (w) begin
                int np = (bp >= TRIES) ? TRIES : bp + 1;
                exp_n = 1; exp_b[0] = 8'h06;
                cmp_frame(e, "R4 write-enable frame"); e++;
                exp_n = 3 + n; exp_b[0] = 8'h02; exp_b[1] = a[15:8]; exp_b[2] = a[7:0];
                for (int k = 0; k < n; k++) exp_b[3 + k] = src_byte(8'(off + k));
                cmp_frame(e, "R2 R3 R4 write frame"); e++;
                for (int j = 0; j < np; j++) begin
                    exp_n = 2; exp_b[0] = 8'h05; exp_b[1] = 8'h00;
                    cmp_frame(e, "R5 status poll frame");
                    if (j > 0)
                        check(lt[e] - lt[e-1] >= PC && lt[e] - lt[e-1] <= PC + 8,
                              "R5 poll spacing", lt[e] - lt[e-1], PC);
                    e++;
                end
            end else begin
                exp_n = 3 + n; exp_b[0] = 8'h03; exp_b[1] = a[15:8]; exp_b[2] = a[7:0];
                for (int k = 0; k < n; k++) exp_b[3 + k] = 8'h00;
                cmp_frame(e, "R2 R3 R7 read frame"); e++;
                for (int k = 0; k < n; k++)
                    check(rdbuf[8'(off + k)] == pat(a + 16'(k)), "R7 read data stored",
                          rdbuf[8'(off + k)], pat(a + 16'(k)));
            end
        end
        check(ntot - log_base == e, "R2 frame count", ntot - log_base, e);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(spi_cs_n && !spi_go && !busy && !done && !timeout && !buf_wr_en,
              "R10 reset state", {spi_cs_n, spi_go, busy, done, timeout, buf_wr_en}, 6'b100000);

        // Table of requests
        for (int v = 0; v < 7; v++) begin
            bit w = VEC[v][32];
            logic [15:0] a = VEC[v][31:16];
            int len = int'(VEC[v][15:8]);
            int bp = int'(VEC[v][7:0]);
            start_req(w, a, len, bp);
            wait_done("table");
            verify(w, a, len, bp);
            check(timeout == (w && bp >= TRIES), "R6 timeout flag", timeout, w && bp >= TRIES);
            if (timeout) begin
                repeat (30) @(negedge clk);
                check(timeout, "R6 timeout sticky while idle", timeout, 1);
            end
        end

        // R1: zero-length request
        log_base = ntot;
        @(negedge clk);
        req_len = '0; req_write = 1'b1; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        check(done && spi_cs_n, "R1 zero length done next cycle", {done, spi_cs_n}, 2'b11);
        repeat (10) @(negedge clk);
        check(ntot == log_base, "R1 no frame for zero length", ntot - log_base, 0);

        // R9: start while busy is ignored
        start_req(1'b1, 16'h0300, 20, 0);
        repeat (10) @(negedge clk);
        req_write = 1'b0; req_addr = 16'h7777; req_len = 8'd5; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        wait_done("R9");
        verify(1'b1, 16'h0300, 20, 0);
        repeat (100) @(negedge clk);
        check(ntot - log_base == 6, "R9 ignored request opened no frame", ntot - log_base, 6);

        // R6: timeout cleared by next accepted request
        start_req(1'b1, 16'h0500, 2, 9);
        wait_done("R6");
        check(timeout, "R6 timeout after limit", timeout, 1);
        start_req(1'b0, 16'h0600, 3, 0);
        check(!timeout, "R6 timeout cleared on accept", timeout, 0);
        wait_done("R6 clear");
        verify(1'b0, 16'h0600, 3, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule